// File: doc/BRIEF.md
# Module Clock Gating Controller

This block decides, for a small set of engine modules, when each module's clock may be switched off and when it must come back. Every module reports two status inputs, idle (nothing to do, starved) and stall (blocked downstream). The controller counts consecutive cycles in which a module sits in a gating-eligible condition. Once the count reaches a programmed threshold, the module's clock-enable output drops. New work, signalled on a per-module wake input, turns the enable back on at once. A per-module ready output then stays low for a programmed number of turn-on cycles, so the module is not used before its clock has settled.

The host programs the block through two writable words and reads one status word. The control word holds a global enable, two bits that exclude the stall or the idle condition as a reason to gate, a 4-bit turn-on wait and a 16-bit idle threshold. The override word holds one bit per module that keeps that module ungated. The status word shows which modules are gated at present. The outputs are enable levels only; the clock-gate cells themselves sit outside this block.

Top module: `modclk_gate_ctrl`

## Requirements
- R1: After reset every module has clock enable high and ready high, and the status word reads zero. The control word and the override word reset to zero.
- R2: While control bit 0 (global enable) is 0, no module is gated, whatever its idle and stall inputs do.
- R3: With global enable set, a module whose gating condition holds for T consecutive cycles is gated. T is control bits 31:16, and a value of 0 acts as 1. The clock enable drops after the T-th such cycle and not before it.
- R4: The idle count restarts from zero whenever the condition lapses for a cycle or a wake request arrives. T further consecutive cycles are then needed before the module is gated.
- R5: When control bit 1 is set, a stall input alone does not count toward gating.
- R6: When control bit 2 is set, an idle input alone does not count toward gating.
- R7: Bit m of the override word (write select 1) keeps module m ungated; bits 0, 1 and 2 map to modules 0, 1 and 2.
- R8: A wake request on a gated module raises its clock enable in the next cycle. Its ready output stays low for N cycles and rises after the N-th, where N is control bits 7:4. With N equal to 0, ready rises together with the enable.
- R9: Clearing the global enable ungates every gated module one cycle after the new control value takes effect.
- R10: Status word bit m is 1 exactly while module m is gated; all other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration words |
| cfg_sel | input | 1 | Write target: 0 selects the control word, 1 selects the override word |
| cfg_wdata | input | DATA_W | Write data |
| mod_idle_i | input | NUM_MOD | Per-module idle (starved) indication |
| mod_stall_i | input | NUM_MOD | Per-module stall indication |
| mod_wake_i | input | NUM_MOD | Per-module new-work request |
| mod_clk_en_o | output | NUM_MOD | Per-module clock enable |
| mod_ready_o | output | NUM_MOD | Per-module ready; low while gated or while waiting to turn on |
| gate_status_o | output | DATA_W | Status word, bit m set while module m is gated |

## Verification
A wrong idle count shows up as a clock enable that falls one or more cycles early or late. That cycle is exactly the T-th eligible edge after the configuration write, so the bench samples the status word on that edge and on the one before. A module stuck in the gated state shows a low enable the cycle after a wake or a disable, and a wrong turn-on counter moves the rising edge of ready away from cycle N after the wake. Mixing up which condition a disable bit removes gates the wrong module in the same threshold window, and that appears at once in the status word.

// File: rtl/modclk_gate_pkg.sv
package modclk_gate_pkg;

   // Field placement inside the control word
   localparam int unsigned CTL_GATE_EN_BIT   = 0;
   localparam int unsigned CTL_NO_STALL_BIT  = 1;
   localparam int unsigned CTL_NO_STARVE_BIT = 2;
   localparam int unsigned CTL_TON_LSB       = 4;
   localparam int unsigned CTL_TON_MAXW      = 4;
   localparam int unsigned CTL_TOFF_LSB      = 16;
   localparam int unsigned CTL_TOFF_MAXW     = 16;

   // Write-select codes
   localparam logic SEL_CTRL     = 1'b0;
   localparam logic SEL_OVERRIDE = 1'b1;

   typedef enum logic [1:0] {
      GS_RUN   = 2'd0,
      GS_GATED = 2'd1,
      GS_WAKE  = 2'd2
   } gate_state_e;

endpackage

// File: rtl/mcg_cfg_regs.sv
module mcg_cfg_regs
   import modclk_gate_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NUM_MOD = 3,
   parameter int unsigned TON_W   = 4,
   parameter int unsigned TOFF_W  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic                sel,
   input  logic [DATA_W-1:0]   wdata,
   output logic                gate_en,
   output logic                no_stall_gate,
   output logic                no_starve_gate,
   output logic [TON_W-1:0]    ton,
   output logic [TOFF_W-1:0]   toff,
   output logic [NUM_MOD-1:0]  mod_dis
);

   logic [DATA_W-1:0]  ctrl_q;
   logic [NUM_MOD-1:0] dis_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         dis_q  <= '0;
      end else if (we) begin
         if (sel == SEL_CTRL) ctrl_q <= wdata;
         else                 dis_q  <= wdata[NUM_MOD-1:0];
      end
   end

   assign gate_en        = ctrl_q[CTL_GATE_EN_BIT];
   assign no_stall_gate  = ctrl_q[CTL_NO_STALL_BIT];
   assign no_starve_gate = ctrl_q[CTL_NO_STARVE_BIT];
   assign ton            = ctrl_q[CTL_TON_LSB +: TON_W];
   assign toff           = ctrl_q[CTL_TOFF_LSB +: TOFF_W];
   assign mod_dis        = dis_q;

   // R7: an override write lands in the override bits only
   p_override_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_OVERRIDE) |=> (mod_dis == $past(wdata[NUM_MOD-1:0])));

endmodule

// File: rtl/mcg_unit.sv
module mcg_unit
   import modclk_gate_pkg::*;
#(
   parameter int unsigned TON_W  = 4,
   parameter int unsigned TOFF_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               allow,
   input  logic               no_stall_gate,
   input  logic               no_starve_gate,
   input  logic [TON_W-1:0]   ton,
   input  logic [TOFF_W-1:0]  toff,
   input  logic               idle_i,
   input  logic               stall_i,
   input  logic               wake_i,
   output logic               clk_en_o,
   output logic               ready_o,
   output logic               gated_o
);

   localparam int unsigned CW = TOFF_W + 1;

   gate_state_e        st_q;
   logic [TOFF_W-1:0]  idle_cnt_q;
   logic [TON_W-1:0]   wait_q;
   logic               eligible;
   logic [CW-1:0]      cnt_nxt;

   assign eligible = allow && ((idle_i && !no_starve_gate) || (stall_i && !no_stall_gate));
   assign cnt_nxt  = {1'b0, idle_cnt_q} + CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= GS_RUN;
         idle_cnt_q <= '0;
         wait_q     <= '0;
      end else begin
         case (st_q)
            GS_RUN: begin
               if (!eligible || wake_i) begin
                  idle_cnt_q <= '0;
               end else if (cnt_nxt >= {1'b0, toff}) begin
                  st_q       <= GS_GATED;
                  idle_cnt_q <= '0;
               end else begin
                  idle_cnt_q <= cnt_nxt[TOFF_W-1:0];
               end
            end
            GS_GATED: begin
               idle_cnt_q <= '0;
               if (!allow || wake_i) begin
                  if (ton == '0) begin
                     st_q <= GS_RUN;
                  end else begin
                     st_q   <= GS_WAKE;
                     wait_q <= ton;
                  end
               end
            end
            GS_WAKE: begin
               idle_cnt_q <= '0;
               if (wait_q <= TON_W'(1)) st_q <= GS_RUN;
               else                     wait_q <= wait_q - TON_W'(1);
            end
            default: st_q <= GS_RUN;
         endcase
      end
   end

   assign clk_en_o = (st_q != GS_GATED);
   assign ready_o  = (st_q == GS_RUN);
   assign gated_o  = (st_q == GS_GATED);

   // R2/R7: a gated module was allowed to gate in the previous cycle
   p_gated_needs_allow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      gated_o |-> $past(allow));

   // R3: gating is entered only from an eligible cycle
   p_gate_from_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gated_o) |-> $past(eligible));

   // R8: wake on a gated module restores the enable in the next cycle
   p_wake_ungates_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (gated_o && wake_i) |=> clk_en_o);

   // R8: a non-zero turn-on wait keeps ready low right after waking
   p_wake_ready_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (gated_o && wake_i && ton != '0) |=> !ready_o);

   // R9: losing permission ungates in the next cycle
   p_disallow_ungates_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (gated_o && !allow) |=> clk_en_o);

endmodule

// File: rtl/modclk_gate_ctrl.sv
module modclk_gate_ctrl
   import modclk_gate_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned NUM_MOD     = 3,
   parameter int unsigned TON_W       = 4,
   parameter int unsigned TOFF_W      = 16,
   parameter bit          SYNC_INPUTS = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic                cfg_sel,
   input  logic [DATA_W-1:0]   cfg_wdata,
   input  logic [NUM_MOD-1:0]  mod_idle_i,
   input  logic [NUM_MOD-1:0]  mod_stall_i,
   input  logic [NUM_MOD-1:0]  mod_wake_i,
   output logic [NUM_MOD-1:0]  mod_clk_en_o,
   output logic [NUM_MOD-1:0]  mod_ready_o,
   output logic [DATA_W-1:0]   gate_status_o
);

   localparam int unsigned STAT_PAD = DATA_W - NUM_MOD;

   // Elaboration checks on the parameter set
   if (DATA_W < CTL_TOFF_LSB + TOFF_W) begin : g_bad_dw
      $error("DATA_W too narrow for the idle threshold field");
   end
   if (TON_W == 0 || TON_W > CTL_TON_MAXW) begin : g_bad_ton
      $error("TON_W out of range");
   end
   if (TOFF_W == 0 || TOFF_W > CTL_TOFF_MAXW) begin : g_bad_toff
      $error("TOFF_W out of range");
   end
   if (NUM_MOD == 0 || NUM_MOD >= DATA_W) begin : g_bad_nm
      $error("NUM_MOD out of range");
   end

   logic               gate_en, no_stall, no_starve;
   logic [TON_W-1:0]   ton;
   logic [TOFF_W-1:0]  toff;
   logic [NUM_MOD-1:0] mod_dis;
   logic [NUM_MOD-1:0] idle_s, stall_s;
   logic [NUM_MOD-1:0] gated;

   mcg_cfg_regs #(
      .DATA_W (DATA_W),
      .NUM_MOD(NUM_MOD),
      .TON_W  (TON_W),
      .TOFF_W (TOFF_W)
   ) cfg_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .we            (cfg_we),
      .sel           (cfg_sel),
      .wdata         (cfg_wdata),
      .gate_en       (gate_en),
      .no_stall_gate (no_stall),
      .no_starve_gate(no_starve),
      .ton           (ton),
      .toff          (toff),
      .mod_dis       (mod_dis)
   );

   // Status inputs either used directly or passed through one register stage
   if (SYNC_INPUTS) begin : g_sync
      logic [NUM_MOD-1:0] idle_q, stall_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            idle_q  <= '0;
            stall_q <= '0;
         end else begin
            idle_q  <= mod_idle_i;
            stall_q <= mod_stall_i;
         end
      end
      assign idle_s  = idle_q;
      assign stall_s = stall_q;
   end else begin : g_direct
      assign idle_s  = mod_idle_i;
      assign stall_s = mod_stall_i;
   end

   for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
      mcg_unit #(
         .TON_W (TON_W),
         .TOFF_W(TOFF_W)
      ) unit_i (
         .clk           (clk),
         .rst_n         (rst_n),
         .allow         (gate_en && !mod_dis[m]),
         .no_stall_gate (no_stall),
         .no_starve_gate(no_starve),
         .ton           (ton),
         .toff          (toff),
         .idle_i        (idle_s[m]),
         .stall_i       (stall_s[m]),
         .wake_i        (mod_wake_i[m]),
         .clk_en_o      (mod_clk_en_o[m]),
         .ready_o       (mod_ready_o[m]),
         .gated_o       (gated[m])
      );
   end

   assign gate_status_o = {{STAT_PAD{1'b0}}, gated};

   // R2: with the global enable off, an all-clear status stays clear
   p_global_off_stays_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_en && gated == '0) |=> (gated == '0));

   // R10: a gated module never shows an active clock enable
   p_status_vs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_status_o[NUM_MOD-1:0] & mod_clk_en_o) == '0);

endmodule

// File: tb/modclk_gate_ctrl_tb_top.sv
module modclk_gate_ctrl_tb_top;

   localparam int unsigned NM = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic          cfg_sel = 1'b0;
   logic [31:0]   cfg_wdata = '0;
   logic [NM-1:0] idle = '0, stall = '0, wake = '0;
   logic [NM-1:0] clk_en, ready;
   logic [31:0]   status;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   modclk_gate_ctrl dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_sel      (cfg_sel),
      .cfg_wdata    (cfg_wdata),
      .mod_idle_i   (idle),
      .mod_stall_i  (stall),
      .mod_wake_i   (wake),
      .mod_clk_en_o (clk_en),
      .mod_ready_o  (ready),
      .gate_status_o(status)
   );

   typedef struct packed {
      logic [3:0]  req;
      logic [31:0] ctrl;
      logic [2:0]  dis;
      logic [2:0]  idl;
      logic [2:0]  stl;
      logic [7:0]  cyc;
      logic [2:0]  exp_gated;
   } vec_t;

   // Control word: bit0 enable, bit1 no-stall, bit2 no-starve, 7:4 turn-on, 31:16 threshold
   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      '{4'd3,  32'h0004_0001, 3'b000, 3'b111, 3'b000, 8'd4,  3'b111}, // R3 exact threshold
      '{4'd3,  32'h0004_0001, 3'b000, 3'b111, 3'b000, 8'd3,  3'b000}, // R3 one short
      '{4'd2,  32'h0004_0000, 3'b000, 3'b111, 3'b111, 8'd10, 3'b000}, // R2 global off
      '{4'd6,  32'h0004_0005, 3'b000, 3'b111, 3'b010, 8'd4,  3'b010}, // R6 idle excluded
      '{4'd5,  32'h0004_0003, 3'b000, 3'b001, 3'b110, 8'd4,  3'b001}, // R5 stall excluded
      '{4'd7,  32'h0004_0001, 3'b101, 3'b111, 3'b000, 8'd4,  3'b010}, // R7 overrides
      '{4'd10, 32'h0004_0007, 3'b000, 3'b111, 3'b111, 8'd8,  3'b000}, // R10 nothing eligible
      '{4'd3,  32'h0001_0001, 3'b000, 3'b100, 3'b000, 8'd1,  3'b100}, // R3 threshold 1
      '{4'd3,  32'h0000_0001, 3'b000, 3'b010, 3'b000, 8'd1,  3'b010}  // R3 threshold 0 acts as 1
   };

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic cfg_write(input logic sel, input logic [31:0] data);
      cfg_sel   = sel;
      cfg_wdata = data;
      cfg_we    = 1'b1;
      tick();
      cfg_we    = 1'b0;
   endtask

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic quiesce();
      idle = '0; stall = '0; wake = '0;
      cfg_write(1'b1, 32'h0);
      cfg_write(1'b0, 32'h0);
      tick(3);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick();

      // R1: reset state
      check("R1", "clk_en", 32'(clk_en), 32'h7);
      check("R1", "ready",  32'(ready),  32'h7);
      check("R1", "status", status,      32'h0);

      // Table walk
      for (int v = 0; v < NV; v++) begin
         quiesce();
         cfg_write(1'b1, {29'd0, VEC[v].dis});
         cfg_write(1'b0, VEC[v].ctrl);
         idle  = VEC[v].idl;
         stall = VEC[v].stl;
         tick(int'(VEC[v].cyc));
         check($sformatf("R%0d", VEC[v].req), $sformatf("status vec%0d", v),
               status, {29'd0, VEC[v].exp_gated});
         check($sformatf("R%0d", VEC[v].req), $sformatf("clk_en vec%0d", v),
               32'(clk_en), {29'd0, ~VEC[v].exp_gated});
      end

      // R4: one lapse restarts the count
      quiesce();
      cfg_write(1'b0, 32'h0004_0001);
      idle = 3'b001;
      tick(3);
      idle = 3'b000;
      tick();
      idle = 3'b001;
      tick(3);
      check("R4", "not gated after lapse", status, 32'h0);
      tick();
      check("R4", "gated after full run", status, 32'h1);

      // R4: a wake while counting also restarts the count
      quiesce();
      cfg_write(1'b0, 32'h0004_0001);
      idle = 3'b001;
      tick(2);
      wake = 3'b001;
      tick();
      wake = 3'b000;
      tick(3);
      check("R4", "not gated after wake in count", status, 32'h0);
      tick();
      check("R4", "gated after restart", status, 32'h1);

      // R8: wake with turn-on wait of 3
      quiesce();
      cfg_write(1'b0, 32'h0004_0031);
      idle = 3'b001;
      tick(4);
      check("R8", "gated before wake", status, 32'h1);
      check("R8", "ready low while gated", 32'(ready[0]), 32'h0);
      idle = 3'b000;
      wake = 3'b001;
      tick();
      wake = 3'b000;
      check("R8", "enable back after wake", 32'(clk_en[0]), 32'h1);
      check("R10", "status clear after wake", status, 32'h0);
      tick(2);
      check("R8", "ready low before wait ends", 32'(ready[0]), 32'h0);
      tick();
      check("R8", "ready high after wait", 32'(ready[0]), 32'h1);

      // R8: zero wait gives ready with the enable
      quiesce();
      cfg_write(1'b0, 32'h0004_0001);
      idle = 3'b100;
      tick(4);
      idle = 3'b000;
      wake = 3'b100;
      tick();
      wake = 3'b000;
      check("R8", "ready with enable at zero wait", 32'(ready), 32'h7);

      // R9: clearing global enable ungates
      quiesce();
      cfg_write(1'b0, 32'h0004_0001);
      idle = 3'b011;
      tick(4);
      check("R9", "gated before clear", status, 32'h3);
      cfg_write(1'b0, 32'h0004_0000);
      tick();
      check("R9", "enables after clear", 32'(clk_en), 32'h7);
      check("R10", "status after clear", status, 32'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule